// File: doc/BRIEF.md
# UART Interrupt Source and Mask Unit

This block gathers the interrupt causes of one serial channel into a single request line. It holds four sticky source bits: receive, error, transmit and modem. A software mask sits beside them. The pending view is the source bits with the masked ones removed, and the interrupt output rises whenever any pending bit is set. Software clears the source bits through two write strobes, each carrying a 4-bit clear pattern.

The transmit and receive trigger conditions are computed here. Each comes from a 3-bit threshold field in the FIFO control word, multiplied by a factor that depends on the channel number. The receive field has one added to it before the multiply. The FIFO storage and the receive timeout counter live outside this block. Their fill counts, the data-ready flag and the timeout event arrive as inputs.

The block also drives a receive-DMA busy line. That line is high while DMA mode is selected and the receive FIFO is empty.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The source vector uses a fixed bit encoding: bit 0 is receive, bit 1 is error, bit 2 is transmit and bit 3 is modem. A high `err_evt_i` sets bit 1 and a high `modem_evt_i` sets bit 3.
- R2: `pend_o` equals `src_o & ~mask_o`. `irq_o` is high exactly when `pend_o` is non-zero.
- R3: A pending-clear write or a source-clear write clears the source bits where `wdata_i` is 1, and therefore clears the same pending bits. Bits where `wdata_i` is 0 keep their value. When both strobes are high, the two clears are combined.
- R4: A mask write loads `wdata_i` into the mask on the next clock edge. Without a mask write, the mask keeps its value. The mask has no effect on the source bits.
- R5: With the FIFO enabled, the transmit condition is `tx_count_i <= tx_trig_i * F`, where F is the channel factor. With the FIFO disabled, the transmit condition is false.
- R6: With the FIFO enabled, the receive condition is true in either of two cases. The first is `rx_count_i >= (rx_trig_i + 1) * F`. The second is `rx_count_i != 0` while `timeout_en_i` is 0.
- R7: The factor F is 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel.
- R8: With the FIFO disabled, the receive condition follows `rx_ready_i`.
- R9: `dma_busy_o` is high exactly when `dma_mode_i == 2'b10` and `rx_count_i == 0`.
- R10: A source bit is set on the clock edge after its condition rises. Once set, the bit stays set until a clear removes it. A set wins over a clear in the same cycle.
- R11: While reset is asserted, the source bits, the mask, the pending bits and `irq_o` are all 0.
- R12: A high `timeout_evt_i` is an extra receive condition, ORed into the receive condition in both FIFO modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enable |
| timeout_en_i | input | 1 | Receive timeout enable |
| dma_mode_i | input | 2 | Receive transfer mode, 2'b10 selects DMA |
| tx_trig_i | input | 3 | Transmit threshold field |
| rx_trig_i | input | 3 | Receive threshold field |
| tx_count_i | input | CNT_W | Transmit FIFO fill count |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_ready_i | input | 1 | Receive data ready when the FIFO is disabled |
| timeout_evt_i | input | 1 | Receive timeout event |
| err_evt_i | input | 1 | Error event |
| modem_evt_i | input | 1 | Modem event |
| mask_we_i | input | 1 | Mask write strobe |
| pend_clr_we_i | input | 1 | Pending-clear write strobe |
| src_clr_we_i | input | 1 | Source-clear write strobe |
| wdata_i | input | 4 | Write data |
| src_o | output | 4 | Source bits |
| mask_o | output | 4 | Mask bits |
| pend_o | output | 4 | Pending bits |
| irq_o | output | 1 | Interrupt request |
| dma_busy_o | output | 1 | Receive DMA busy |

## Verification
A source-bit set and a software clear of the same bit can fall in the same cycle. The bench provokes this directly: it lowers a condition, then raises it again while a clear write to the same bit is on the port. Random traffic makes the collision recur, mixing event pulses, count changes and clear writes in the same cycles. In every case the bit must come out set, and a later clear with its condition held steady must remove it.

The bench checks three instances with channel factors 2, 32 and 0 against a model. The model builds each condition from the formulas in R5 to R8 and R12.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NSRC   = 4;
  localparam int unsigned TRIG_W = 3;
  localparam int unsigned LVL_W  = TRIG_W + 1 + 5;  // (field+1) * 32

  localparam int unsigned SRC_RX    = 0;
  localparam int unsigned SRC_ERR   = 1;
  localparam int unsigned SRC_TX    = 2;
  localparam int unsigned SRC_MODEM = 3;

  localparam logic [1:0] DMA_MODE = 2'b10;

  function automatic int unsigned trig_scale(input int unsigned ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig
  import uart_irq_pkg::*;
#(
  parameter int unsigned CHANNEL = 0,
  parameter int unsigned CNT_W   = 8
) (
  input  logic              fifo_en_i,
  input  logic              timeout_en_i,
  input  logic [TRIG_W-1:0] tx_trig_i,
  input  logic [TRIG_W-1:0] rx_trig_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              rx_ready_i,
  input  logic              timeout_evt_i,
  output logic              tx_cond_o,
  output logic              rx_cond_o
);
  localparam int unsigned FACTOR = trig_scale(CHANNEL);
  localparam int unsigned CMP_W  = ((CNT_W > LVL_W) ? CNT_W : LVL_W) + 1;

  logic [CMP_W-1:0] tx_lvl, rx_lvl, tx_cnt_x, rx_cnt_x;
  logic             rx_fifo_hit;

  always_comb begin
    tx_lvl   = CMP_W'(tx_trig_i) * CMP_W'(FACTOR);
    rx_lvl   = (CMP_W'(rx_trig_i) + CMP_W'(1)) * CMP_W'(FACTOR);
    tx_cnt_x = CMP_W'(tx_count_i);
    rx_cnt_x = CMP_W'(rx_count_i);
  end

  assign rx_fifo_hit = (rx_cnt_x >= rx_lvl) || ((rx_count_i != '0) && !timeout_en_i);
  assign tx_cond_o   = fifo_en_i && (tx_cnt_x <= tx_lvl);
  assign rx_cond_o   = (fifo_en_i ? rx_fifo_hit : rx_ready_i) || timeout_evt_i;

  // R5: no transmit trigger without FIFO mode
  always_comb p_tx_needs_fifo_r5: assert (!tx_cond_o || fifo_en_i);
  // R8: FIFO disabled, receive follows ready/timeout only
  always_comb p_rx_nofifo_r8: assert (fifo_en_i || (rx_cond_o == (rx_ready_i || timeout_evt_i)));
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] cond_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] src_o
);
  logic [NSRC-1:0] cond_q, src_q, set_pulse;

  assign set_pulse = cond_i & ~cond_q;
  assign src_o     = src_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cond_q[i] <= 1'b0;
        src_q[i]  <= 1'b0;
      end else begin
        cond_q[i] <= cond_i[i];
        if (set_pulse[i])   src_q[i] <= 1'b1;
        else if (clr_i[i])  src_q[i] <= 1'b0;
      end
    end

    p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_pulse[i] |=> src_q[i]);
    p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_q[i] && !clr_i[i]) |=> src_q[i]);
    p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_pulse[i]) |=> !src_q[i]);
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned CHANNEL = 0,
  parameter int unsigned CNT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              timeout_en_i,
  input  logic [1:0]        dma_mode_i,
  input  logic [TRIG_W-1:0] tx_trig_i,
  input  logic [TRIG_W-1:0] rx_trig_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              rx_ready_i,
  input  logic              timeout_evt_i,
  input  logic              err_evt_i,
  input  logic              modem_evt_i,
  input  logic              mask_we_i,
  input  logic              pend_clr_we_i,
  input  logic              src_clr_we_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   src_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   pend_o,
  output logic              irq_o,
  output logic              dma_busy_o
);
  logic            tx_cond, rx_cond;
  logic [NSRC-1:0] cond, clr, mask_q, src;

  uart_irq_trig #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) u_trig (
    .fifo_en_i    (fifo_en_i),
    .timeout_en_i (timeout_en_i),
    .tx_trig_i    (tx_trig_i),
    .rx_trig_i    (rx_trig_i),
    .tx_count_i   (tx_count_i),
    .rx_count_i   (rx_count_i),
    .rx_ready_i   (rx_ready_i),
    .timeout_evt_i(timeout_evt_i),
    .tx_cond_o    (tx_cond),
    .rx_cond_o    (rx_cond)
  );

  always_comb begin
    cond            = '0;
    cond[SRC_RX]    = rx_cond;
    cond[SRC_ERR]   = err_evt_i;
    cond[SRC_TX]    = tx_cond;
    cond[SRC_MODEM] = modem_evt_i;
    clr = ({NSRC{pend_clr_we_i}} | {NSRC{src_clr_we_i}}) & wdata_i;
  end

  uart_irq_src u_src (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cond_i(cond),
    .clr_i (clr),
    .src_o (src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= wdata_i;
  end

  assign src_o      = src;
  assign mask_o     = mask_q;
  assign pend_o     = src & ~mask_q;
  assign irq_o      = |pend_o;
  assign dma_busy_o = (dma_mode_i == DMA_MODE) && (rx_count_i == '0);

  p_mask_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));
  p_mask_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_q == $past(wdata_i)));
  p_irq_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (src != '0));
  p_dma_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_busy_o |-> (rx_count_i == '0));
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  localparam int NI = 3;
  localparam int unsigned FAC [NI] = '{2, 32, 0};  // channels 2, 0, 7 (R7)

  logic clk = 0, rst_ni = 0;
  always #10 clk = ~clk;

  logic       fifo_en, to_en, rx_ready, to_evt, err_evt, modem_evt;
  logic       mask_we, pclr_we, sclr_we;
  logic [1:0] dma_mode;
  logic [2:0] tx_trig, rx_trig;
  logic [7:0] tx_cnt, rx_cnt;
  logic [3:0] wdata;

  logic [3:0] src_o [NI], mask_o [NI], pend_o [NI];
  logic       irq_o [NI], dma_o [NI];

  int checks = 0, fails = 0;
  logic [3:0] m_src [NI], m_mask [NI], m_prev [NI];

  `define DUT_INST(NAME, IDX, CH) \
    uart_irq_ctrl #(.CHANNEL(CH)) NAME ( \
      .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en), .timeout_en_i(to_en), \
      .dma_mode_i(dma_mode), .tx_trig_i(tx_trig), .rx_trig_i(rx_trig), \
      .tx_count_i(tx_cnt), .rx_count_i(rx_cnt), .rx_ready_i(rx_ready), \
      .timeout_evt_i(to_evt), .err_evt_i(err_evt), .modem_evt_i(modem_evt), \
      .mask_we_i(mask_we), .pend_clr_we_i(pclr_we), .src_clr_we_i(sclr_we), \
      .wdata_i(wdata), .src_o(src_o[IDX]), .mask_o(mask_o[IDX]), \
      .pend_o(pend_o[IDX]), .irq_o(irq_o[IDX]), .dma_busy_o(dma_o[IDX]));

  `DUT_INST(u_dut, 0, 2)
  `DUT_INST(u_dut_ch0, 1, 0)
  `DUT_INST(u_dut_ch7, 2, 7)

  function automatic logic [3:0] exp_cond(int unsigned f);
    logic [3:0] c;
    int unsigned txl = tx_trig * f, rxl = (rx_trig + 1) * f;
    c[0] = (fifo_en ? ((rx_cnt >= rxl) || (rx_cnt != 0 && !to_en)) : rx_ready) || to_evt; // R6 R8 R12
    c[1] = err_evt;                       // R1
    c[2] = fifo_en && (tx_cnt <= txl);    // R5
    c[3] = modem_evt;                     // R1
    return c;
  endfunction

  task automatic chk(string tag, int i, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s inst%0d act=%h exp=%h t=%0t", tag, i, act, exp, $time);
    end
  endtask

  task automatic idle();
    fifo_en = 1; to_en = 1; rx_ready = 0; to_evt = 0; err_evt = 0; modem_evt = 0;
    mask_we = 0; pclr_we = 0; sclr_we = 0; dma_mode = 0;
    tx_trig = 0; rx_trig = 7; tx_cnt = 8'd200; rx_cnt = 0; wdata = 0;
  endtask

  // inputs already applied; advance one edge and compare at negedge
  task automatic step();
    logic [3:0] clr = ((pclr_we || sclr_we) ? wdata : 4'h0);
    for (int i = 0; i < NI; i++) begin
      logic [3:0] c = exp_cond(FAC[i]);
      m_src[i]  = (m_src[i] & ~clr) | (c & ~m_prev[i]);   // R10 R3
      m_prev[i] = c;
      if (mask_we) m_mask[i] = wdata;                   // R4
    end
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      chk("R1 R3 R5 R6 R7 R8 R10 R12 src", i, src_o[i], m_src[i]);
      chk("R4 mask", i, mask_o[i], m_mask[i]);
      chk("R2 pend", i, pend_o[i], m_src[i] & ~m_mask[i]);
      chk("R2 irq", i, {3'b0, irq_o[i]}, {3'b0, |(m_src[i] & ~m_mask[i])});
      chk("R9 dma", i, {3'b0, dma_o[i]}, {3'b0, (dma_mode == 2'b10) && (rx_cnt == 0)});
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    idle();
    for (int i = 0; i < NI; i++) begin m_src[i] = 0; m_mask[i] = 0; m_prev[i] = 0; end
    // R11: held in reset with active conditions
    err_evt = 1; mask_we = 1; wdata = 4'hF;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      chk("R11 src", i, src_o[i], 4'h0);
      chk("R11 mask", i, mask_o[i], 4'h0);
      chk("R11 irq", i, {3'b0, irq_o[i]}, 4'h0);
    end
    idle();
    rst_ni = 1;
    step();
    // R1: error then modem
    err_evt = 1; step(); err_evt = 0; modem_evt = 1; step(); modem_evt = 0; step();
    // R3: pending-clear of error only
    pclr_we = 1; wdata = 4'h2; step(); pclr_we = 0;
    // R10: set wins over same-cycle clear
    err_evt = 1; sclr_we = 1; wdata = 4'h2; step(); sclr_we = 0; err_evt = 0; step();
    // R5: tx count at exact level, ch2 trig 3 -> 6
    tx_trig = 3; tx_cnt = 6; step(); tx_cnt = 7; sclr_we = 1; wdata = 4'h4; step(); sclr_we = 0;
    // R6: rx reaches (1+1)*2 = 4 on ch2
    rx_trig = 1; rx_cnt = 3; step(); rx_cnt = 4; step();
    rx_cnt = 0; sclr_we = 1; wdata = 4'hF; step(); sclr_we = 0;
    // R6: non-zero count with timeout disabled
    rx_trig = 7; to_en = 0; rx_cnt = 1; step(); to_en = 1; rx_cnt = 0; pclr_we = 1; wdata = 4'h1; step(); pclr_we = 0;
    // R8: FIFO disabled, ready drives receive
    fifo_en = 0; rx_ready = 1; step(); rx_ready = 0; pclr_we = 1; wdata = 4'hF; step(); pclr_we = 0;
    // R12: timeout event
    to_evt = 1; step(); to_evt = 0; fifo_en = 1; step();
    // R4 R2: mask hides pending
    mask_we = 1; wdata = 4'h5; step(); mask_we = 0; step();
    // R9: DMA mode with empty and non-empty rx
    dma_mode = 2'b10; step(); rx_cnt = 2; step(); dma_mode = 2'b01; rx_cnt = 0; step();
    // random
    for (int n = 0; n < 3000; n++) begin
      fifo_en   = ($urandom_range(0, 9) != 0);
      to_en     = $urandom_range(0, 1);
      rx_ready  = $urandom_range(0, 1);
      to_evt    = ($urandom_range(0, 9) == 0);
      err_evt   = ($urandom_range(0, 4) == 0);
      modem_evt = ($urandom_range(0, 4) == 0);
      dma_mode  = 2'($urandom_range(0, 3));
      tx_trig   = 3'($urandom_range(0, 7));
      rx_trig   = 3'($urandom_range(0, 7));
      tx_cnt    = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 20));
      rx_cnt    = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 20));
      mask_we   = ($urandom_range(0, 6) == 0);
      pclr_we   = ($urandom_range(0, 3) == 0);
      sclr_we   = ($urandom_range(0, 3) == 0);
      wdata     = 4'($urandom_range(0, 15));
      step();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule